// File: doc/BRIEF.md
# Multiplexed Bar-Graph Capacity Display Driver

This block turns a remaining-capacity value into a five-segment bar graph, where each segment stands for one fifth of a learned full-capacity reference. It drives the segments in two alternating banks so that only part of the LED array draws current at any moment. It also decides when the display is lit, using a three-way display selector, a charge-in-progress input and a timed window that opens on demand.

Two battery-warning inputs change what is shown. An early low-capacity warning makes the lowest segment blink. A final empty warning blanks every segment. All timing comes from one slow tick-enable input through internal counters, and each counter reload is a parameter. The mux period, bank on-time, blink half-period and timed-window length are all given in ticks.

Top module: `bar_graph_driver`

## Requirements
- R1: The number of lit segments equals the count of k in 1..NUM_SEG-1 for which NUM_SEG·cap ≥ k·full, plus one when cap is nonzero. Segments light from the lowest upward, and segment 1 is bit 0.
- R2: Segment enables are active low: seg_n[i] = 0 drives segment i+1.
- R3: With disp_sel = 2'b10 or 2'b11 (display forced off), com_en is 0 and every seg_n bit is 1.
- R4: With disp_sel = 2'b01 (charge-only), the display is on exactly when charging is 1.
- R5: disp_sel = 2'b00 (timed) keeps the display on for TIMED_LEN ticks after the selector enters that value. With tick held high, com_en stays high for exactly TIMED_LEN consecutive cycles. With tick held low, the window does not close.
- R6: Leaving 2'b00 and entering it again restarts the full timed window. Entering 2'b00 straight out of reset also opens a window.
- R7: Odd-numbered segments (1, 3, 5) form bank A and even-numbered segments (2, 4) form bank B. The two banks are never driven in the same cycle.
- R8: Each lit segment is driven for BANK_ON ticks out of every MUX_PERIOD ticks.
- R9: While warn_low is 1, segment 1 is gated by a square wave of BLINK_HALF ticks per half, starting in the on half after reset. Other segments are not affected.
- R10: While warn_empty is 1, all segment enables are 1. com_en still follows the display state.
- R11: com_en is 0 whenever the display is off, and no segment is driven while com_en is 0.
- R12: During reset, seg_n is all ones and com_en is 0.
- R13: Every output is registered. A change on cap, full, disp_sel, charging, warn_low or warn_empty shows on the outputs one clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; all display timing counts these |
| cap | input | CAP_W | Compensated remaining capacity |
| full | input | CAP_W | Learned full-capacity reference |
| disp_sel | input | 2 | Display selector: 00 timed, 01 charge-only, 1x off |
| charging | input | 1 | Charge in progress |
| warn_low | input | 1 | Early low-capacity warning (blink segment 1) |
| warn_empty | input | 1 | Final empty warning (blank all segments) |
| seg_n | output | NUM_SEG | Active-low segment enables, bit 0 = segment 1 |
| com_en | output | 1 | Common LED drive enable |

## Verification
Level, selector and warning changes are due on the outputs one clock after the edge that samples them. The bench therefore lets two clocks pass after each input change before it observes anything. Segment patterns are judged over a whole mux period, so the result does not depend on the bank phase. Bank duty and blink gating are measured as lit-cycle counts over windows that are whole multiples of their periods, which makes the totals the same for any starting phase. The timed window is measured by counting consecutive high samples of com_en, beginning at the clock that samples the selector entering its timed value.

// File: rtl/bargraph_pkg.sv
package bargraph_pkg;

   typedef enum logic [1:0] {
      DSP_TIMED   = 2'b00,
      DSP_CHARGE  = 2'b01,
      DSP_OFF     = 2'b10,
      DSP_OFF_ALT = 2'b11
   } disp_sel_e;

   // Mask of segments belonging to one bank: bank 0 holds even indices
   // (segments 1,3,5...), bank 1 holds odd indices (segments 2,4...).
   function automatic logic [31:0] bank_mask(input int unsigned nseg, input int unsigned bank);
      logic [31:0] m;
      m = '0;
      for (int unsigned i = 0; i < nseg; i++) begin
         if ((i % 2) == bank) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/bar_level.sv
module bar_level #(
   parameter int CAP_W   = 16,
   parameter int NUM_SEG = 5
) (
   input  logic [CAP_W-1:0]   cap_i,
   input  logic [CAP_W-1:0]   full_i,
   output logic [NUM_SEG-1:0] lit_o
);
   localparam int CNT_W = $clog2(NUM_SEG + 1);
   localparam int MUL_W = CAP_W + CNT_W + 1;

   logic [MUL_W-1:0]   cap_scaled;
   logic [NUM_SEG-2:0] meets;
   logic [CNT_W-1:0]   level;

   assign cap_scaled = MUL_W'(cap_i) * MUL_W'(NUM_SEG);

   generate
      for (genvar k = 1; k < NUM_SEG; k++) begin : g_thr
         logic [MUL_W-1:0] thr;
         assign thr          = MUL_W'(full_i) * MUL_W'(k);
         assign meets[k-1]   = (cap_scaled >= thr);
      end
   endgenerate

   always_comb begin
      level = CNT_W'($countones(meets)) + CNT_W'(cap_i != '0);
   end

   generate
      for (genvar i = 0; i < NUM_SEG; i++) begin : g_therm
         assign lit_o[i] = (level > CNT_W'(i));
      end
   endgenerate

endmodule

// File: rtl/bar_timing.sv
module bar_timing #(
   parameter int MUX_PERIOD = 10,
   parameter int BANK_ON    = 3,
   parameter int BLINK_HALF = 125,
   parameter int TIMED_LEN  = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic timed_sel_i,
   output logic bank_a_o,
   output logic bank_b_o,
   output logic blink_o,
   output logic win_open_o
);
   localparam int PH_W  = $clog2(MUX_PERIOD + 1);
   localparam int HALF  = MUX_PERIOD / 2;
   localparam int WIN_W = $clog2(TIMED_LEN + 1);

   logic [PH_W-1:0]  phase;
   logic [WIN_W-1:0] win_cnt;
   logic             prev_timed;
   logic             start;

   // mux phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  phase <= '0;
      else if (tick_i) begin
         if (phase == PH_W'(MUX_PERIOD - 1))       phase <= '0;
         else                                      phase <= phase + 1'b1;
      end
   end

   assign bank_a_o = (phase < PH_W'(BANK_ON));
   assign bank_b_o = (phase >= PH_W'(HALF)) && (phase < PH_W'(HALF + BANK_ON));

   // blink square wave, variant chosen by half-period length
   generate
      if (BLINK_HALF == 1) begin : g_blink_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      blink_o <= 1'b1;
            else if (tick_i) blink_o <= ~blink_o;
         end
      end else begin : g_blink_cnt
         localparam int BL_W = $clog2(BLINK_HALF + 1);
         logic [BL_W-1:0] bl_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bl_cnt  <= '0;
               blink_o <= 1'b1;
            end else if (tick_i) begin
               if (bl_cnt == BL_W'(BLINK_HALF - 1)) begin
                  bl_cnt  <= '0;
                  blink_o <= ~blink_o;
               end else begin
                  bl_cnt  <= bl_cnt + 1'b1;
               end
            end
         end
      end
   endgenerate

   // timed window
   assign start = timed_sel_i && !prev_timed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_timed <= 1'b0;
         win_cnt    <= '0;
      end else begin
         prev_timed <= timed_sel_i;
         if (start)                        win_cnt <= WIN_W'(TIMED_LEN - 1);
         else if (tick_i && win_cnt != '0) win_cnt <= win_cnt - 1'b1;
      end
   end

   assign win_open_o = timed_sel_i && (start || win_cnt != '0);

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase < PH_W'(MUX_PERIOD)); // R8
   AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      win_cnt <= WIN_W'(TIMED_LEN - 1)); // R5
   AST_WINDOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (timed_sel_i && !prev_timed) |=> win_cnt == WIN_W'(TIMED_LEN - 1)); // R6
   AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && prev_timed && timed_sel_i) |=> $stable(win_cnt)); // R5

endmodule

// File: rtl/bar_graph_driver.sv
module bar_graph_driver
   import bargraph_pkg::*;
#(
   parameter int CAP_W      = 16,
   parameter int NUM_SEG    = 5,
   parameter int MUX_PERIOD = 10,
   parameter int BANK_ON    = 3,
   parameter int BLINK_HALF = 125,
   parameter int TIMED_LEN  = 4000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [CAP_W-1:0]   cap,
   input  logic [CAP_W-1:0]   full,
   input  logic [1:0]         disp_sel,
   input  logic               charging,
   input  logic               warn_low,
   input  logic               warn_empty,
   output logic [NUM_SEG-1:0] seg_n,
   output logic               com_en
);
   localparam logic [31:0]        MASK_A32 = bank_mask(NUM_SEG, 0);
   localparam logic [31:0]        MASK_B32 = bank_mask(NUM_SEG, 1);
   localparam logic [NUM_SEG-1:0] MASK_A   = MASK_A32[NUM_SEG-1:0];
   localparam logic [NUM_SEG-1:0] MASK_B   = MASK_B32[NUM_SEG-1:0];

   generate
      if (NUM_SEG < 2 || NUM_SEG > 32)        $error("NUM_SEG out of range");
      if (BANK_ON < 1)                        $error("BANK_ON must be at least 1");
      if (BANK_ON > MUX_PERIOD - MUX_PERIOD/2) $error("bank windows overlap");
      if (TIMED_LEN < 1 || BLINK_HALF < 1)    $error("timer reloads must be nonzero");
      if (CAP_W < 1)                          $error("CAP_W must be positive");
   endgenerate

   disp_sel_e            sel;
   logic [NUM_SEG-1:0]   lit;
   logic [NUM_SEG-1:0]   drive;
   logic                 bank_a, bank_b, blink_on, win_open;
   logic                 active;

   assign sel = disp_sel_e'(disp_sel);

   bar_level #(
      .CAP_W   (CAP_W),
      .NUM_SEG (NUM_SEG)
   ) u_level (
      .cap_i  (cap),
      .full_i (full),
      .lit_o  (lit)
   );

   bar_timing #(
      .MUX_PERIOD (MUX_PERIOD),
      .BANK_ON    (BANK_ON),
      .BLINK_HALF (BLINK_HALF),
      .TIMED_LEN  (TIMED_LEN)
   ) u_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .timed_sel_i (sel == DSP_TIMED),
      .bank_a_o    (bank_a),
      .bank_b_o    (bank_b),
      .blink_o     (blink_on),
      .win_open_o  (win_open)
   );

   always_comb begin
      unique case (sel)
         DSP_TIMED:  active = win_open;
         DSP_CHARGE: active = charging;
         default:    active = 1'b0;
      endcase
   end

   generate
      for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
         logic in_bank;
         logic gate;
         assign in_bank = ((i % 2) == 0) ? bank_a : bank_b;
         assign gate    = (i == 0) ? (!warn_low || blink_on) : 1'b1;
         assign drive[i] = active && !warn_empty && lit[i] && in_bank && gate;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_n  <= '1;
         com_en <= 1'b0;
      end else begin
         seg_n  <= ~drive;
         com_en <= active;
      end
   end

   AST_BANKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(((~seg_n & MASK_A) != '0) && ((~seg_n & MASK_B) != '0))); // R7
   AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      disp_sel[1] |=> (!com_en && (&seg_n))); // R3
   AST_CHARGE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_sel == 2'b01) |=> (com_en == $past(charging))); // R4
   AST_EMPTY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      warn_empty |=> (&seg_n)); // R10
   AST_NO_SEG_WITHOUT_COM: assert property (@(posedge clk) disable iff (!rst_n)
      !com_en |-> (&seg_n)); // R11
   AST_FULL_LIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cap != '0 && cap >= full) |-> (&lit)); // R1

endmodule

// File: tb/test_bar_graph_driver.sv
module test_bar_graph_driver;

   localparam int NSEG = 5;
   localparam int MUXP = 10;
   localparam int BON  = 3;
   localparam int BLH  = 20;
   localparam int TLEN = 50;

   typedef struct packed {
      logic [15:0] cap;
      logic [15:0] full;
      logic [1:0]  sel;
      logic        chg;
      logic        emp;
      logic [4:0]  mask;
      logic        com;
   } vec_t;

   // R1/R2 level patterns, R3/R4/R10 mode cases (full = 1000)
   localparam vec_t VEC [13] = '{
      '{16'd0,    16'd1000, 2'b01, 1'b1, 1'b0, 5'b00000, 1'b1}, // R1 empty count
      '{16'd1,    16'd1000, 2'b01, 1'b1, 1'b0, 5'b00001, 1'b1}, // R1 any charge
      '{16'd199,  16'd1000, 2'b01, 1'b1, 1'b0, 5'b00001, 1'b1}, // R1 below 20%
      '{16'd200,  16'd1000, 2'b01, 1'b1, 1'b0, 5'b00011, 1'b1}, // R1 at 20%
      '{16'd599,  16'd1000, 2'b01, 1'b1, 1'b0, 5'b00111, 1'b1}, // R1 below 60%
      '{16'd600,  16'd1000, 2'b01, 1'b1, 1'b0, 5'b01111, 1'b1}, // R1 at 60%
      '{16'd800,  16'd1000, 2'b01, 1'b1, 1'b0, 5'b11111, 1'b1}, // R1 at 80%
      '{16'd1000, 16'd1000, 2'b01, 1'b1, 1'b0, 5'b11111, 1'b1}, // R1 full
      '{16'd1200, 16'd1000, 2'b01, 1'b1, 1'b0, 5'b11111, 1'b1}, // R1 over full
      '{16'd500,  16'd1000, 2'b01, 1'b0, 1'b0, 5'b00000, 1'b0}, // R4 not charging
      '{16'd500,  16'd1000, 2'b10, 1'b1, 1'b0, 5'b00000, 1'b0}, // R3 off
      '{16'd500,  16'd1000, 2'b11, 1'b1, 1'b0, 5'b00000, 1'b0}, // R3 off alt
      '{16'd1000, 16'd1000, 2'b01, 1'b1, 1'b1, 5'b00000, 1'b1}  // R10 blank
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick = 1'b1;
   logic [15:0]     cap = '0;
   logic [15:0]     full = 16'd1000;
   logic [1:0]      disp_sel = 2'b01;
   logic            charging = 1'b0;
   logic            warn_low = 1'b0;
   logic            warn_empty = 1'b0;
   logic [NSEG-1:0] seg_n;
   logic            com_en;

   int n_checks = 0;
   int n_fail   = 0;

   logic [NSEG-1:0] acc_mask;
   logic            com_any, com_all, overlap;
   int              cnt_s1, cnt_s2, cnt_s3;

   always #5 clk = ~clk;

   bar_graph_driver #(
      .CAP_W (16), .NUM_SEG (NSEG), .MUX_PERIOD (MUXP),
      .BANK_ON (BON), .BLINK_HALF (BLH), .TIMED_LEN (TLEN)
   ) i_bar_graph_driver (
      .clk (clk), .rst_n (rst_n), .tick (tick), .cap (cap), .full (full),
      .disp_sel (disp_sel), .charging (charging), .warn_low (warn_low),
      .warn_empty (warn_empty), .seg_n (seg_n), .com_en (com_en)
   );

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic observe(input int n);
      acc_mask = '0; com_any = 1'b0; com_all = 1'b1; overlap = 1'b0;
      cnt_s1 = 0; cnt_s2 = 0; cnt_s3 = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         acc_mask = acc_mask | ~seg_n;
         com_any  = com_any | com_en;
         com_all  = com_all & com_en;
         if ((~seg_n & 5'b10101) != 0 && (~seg_n & 5'b01010) != 0) overlap = 1'b1;
         if (!seg_n[0]) cnt_s1++;
         if (!seg_n[1]) cnt_s2++;
         if (!seg_n[2]) cnt_s3++;
      end
   endtask

   task automatic count_window(output int len);
      len = 0;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (com_en) len++;
         else break;
      end
   endtask

   task automatic finish_run;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(1_000_000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int len;
      // R12 reset state
      step(3);
      chk(seg_n == '1, "R12", "seg_n in reset", seg_n, 5'h1f);
      chk(com_en == 1'b0, "R12", "com_en in reset", com_en, 0);
      rst_n = 1'b1;

      // vector table: R1 R2 R3 R4 R10
      foreach (VEC[v]) begin
         @(negedge clk);
         cap = VEC[v].cap; full = VEC[v].full; disp_sel = VEC[v].sel;
         charging = VEC[v].chg; warn_empty = VEC[v].emp;
         step(2);
         observe(MUXP);
         chk(acc_mask == VEC[v].mask, "R1/R2/R3/R10", $sformatf("vec %0d lit mask", v),
             acc_mask, VEC[v].mask);
         chk(com_any == VEC[v].com && com_all == VEC[v].com, "R4/R11",
             $sformatf("vec %0d com_en", v), com_any, VEC[v].com);
      end

      // R7 R8 duty and bank exclusivity, all lit
      warn_empty = 1'b0; cap = 16'd1000; disp_sel = 2'b01; charging = 1'b1;
      step(2);
      observe(2 * MUXP);
      chk(!overlap, "R7", "banks overlap", overlap, 0);
      chk(cnt_s1 == 2 * BON, "R8", "segment1 duty", cnt_s1, 2 * BON);
      chk(cnt_s2 == 2 * BON, "R8", "segment2 duty", cnt_s2, 2 * BON);

      // R9 blink: window of 4*BLH covers whole blink and mux periods
      warn_low = 1'b1;
      step(2);
      observe(4 * BLH);
      chk(cnt_s1 == (4 * BLH / MUXP) * BON / 2, "R9", "segment1 blink count",
          cnt_s1, (4 * BLH / MUXP) * BON / 2);
      chk(cnt_s3 == (4 * BLH / MUXP) * BON, "R9", "segment3 steady count",
          cnt_s3, (4 * BLH / MUXP) * BON);
      warn_low = 1'b0;

      // R13 one-cycle latency
      @(negedge clk);
      warn_empty = 1'b1;
      @(negedge clk);
      chk(seg_n == '1, "R13", "blank after one clock", seg_n, 5'h1f);
      warn_empty = 1'b0;
      charging = 1'b0;
      @(negedge clk);
      chk(com_en == 1'b0, "R13", "com off after one clock", com_en, 0);

      // R5 timed window length
      disp_sel = 2'b10;
      step(3);
      disp_sel = 2'b00;
      count_window(len);
      chk(len == TLEN, "R5", "timed window cycles", len, TLEN);
      step(5);
      chk(com_en == 1'b0 && seg_n == '1, "R5", "display dark after window", com_en, 0);

      // R6 restart on re-entry
      disp_sel = 2'b10;
      step(2);
      disp_sel = 2'b00;
      step(20);
      disp_sel = 2'b10;
      step(1);
      disp_sel = 2'b00;
      count_window(len);
      chk(len == TLEN, "R6", "restarted window cycles", len, TLEN);

      // R5 window frozen without ticks
      disp_sel = 2'b10;
      step(2);
      tick = 1'b0;
      disp_sel = 2'b00;
      step(4 * TLEN);
      chk(com_en == 1'b1, "R5", "window held without tick", com_en, 1);
      tick = 1'b1;
      count_window(len);
      chk(len == TLEN - 1, "R5", "remaining window after ticks resume", len, TLEN - 1);

      finish_run();
   end

endmodule